// File: doc/BRIEF.md
# Channel Report Word Queue

This block holds pending channel report words for a consumer that collects them one at a time. Producers present a report as a source code, a recovery code, a chain indication and a 16-bit resource identifier; the block packs these into a 32-bit word and appends it to a first-in first-out queue of parameterised depth. A consumer issues a store request and, one cycle later, receives either the oldest queued word with a success status or an all-zero word with an empty status.

Two conditions are reported in-band. If a report cannot be stored because the queue is full, a sticky loss flag is raised, and the next report that is stored carries an overflow marker. The machine-check notification to the consumer is one-shot. The queue is armed at reset. The first stored report then produces a single pulse and disarms it. Only a store request that finds the queue empty arms it again.

Top module: `crw_queue`

## Requirements
- R1: The stored word is {bit31 = 0, bit30 = overflow marker, bit29 = chain, bits28:24 = source code, bits23:16 = recovery code, bits15:0 = resource id}, so the flags half equals (source << 8) | recovery code plus the marker bits.
- R2: A store request to a non-empty queue returns the oldest entry with pop_status = 0; pop_ack, pop_word and pop_status are valid in the cycle after pop_req.
- R3: A store request to an empty queue, with no push in the same cycle, returns pop_word = 0 with pop_status = 1.
- R4: A push while the queue holds DEPTH entries and no entry is popped in that cycle is discarded and marks a loss.
- R5: After a loss, the next accepted push carries bit 30 set, and the loss flag is cleared by that push, so later entries carry bit 30 clear.
- R6: mchk_pulse is high for exactly one cycle, in the cycle after an accepted push made while armed; that push disarms the queue, so later pushes raise no pulse.
- R7: A store request that returns the empty status re-arms the queue, so the next accepted push raises mchk_pulse again.
- R8: After reset the queue is empty, armed, the loss flag is clear, and pop_ack, pop_status, pop_word and mchk_pulse are 0.
- R9: A push and a store request in the same cycle on an empty queue return the new entry with status 0, and the queue stays empty.
- R10: A push and a store request in the same cycle on a full queue are both honoured: the head is returned, the new entry is stored, and no loss is marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Producer presents a report this cycle |
| push_src | input | 5 | Reporting source code |
| push_erc | input | 8 | Error-recovery code |
| push_chain | input | 1 | Report is chained to the next one |
| push_rsid | input | 16 | Resource identifier |
| pop_req | input | 1 | Consumer store request |
| pop_ack | output | 1 | Store result valid (one cycle after pop_req) |
| pop_status | output | 1 | 1 when the queue was empty, 0 when a word was returned |
| pop_word | output | 32 | Returned report word |
| mchk_pulse | output | 1 | One-cycle machine-check notification |

## Verification
Every result of this block is registered once. The store response and the machine-check pulse are therefore both due at the first rising edge after the cycle that drove the push or store request. The driver applies each cycle's inputs on the falling edge and queues what the model expects for that edge. The monitor samples shortly after the next rising edge and consumes exactly one expectation per driven cycle, so a response or pulse that arrives a cycle early or late shows up as a mismatch.

// File: rtl/crw_queue.sv
module crw_queue #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_valid,
  input  logic [4:0]  push_src,
  input  logic [7:0]  push_erc,
  input  logic        push_chain,
  input  logic [15:0] push_rsid,
  input  logic        pop_req,
  output logic        pop_ack,
  output logic        pop_status,
  output logic [31:0] pop_word,
  output logic        mchk_pulse
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          lost, armed;

  wire empty     = (count == '0);
  wire full      = (count == CW'(DEPTH));
  wire do_pop    = pop_req && !empty;
  wire accept    = push_valid && (!full || do_pop);
  wire bypass    = accept && pop_req && empty;
  wire store     = accept && !bypass;
  wire empty_rd  = pop_req && empty && !accept;
  wire [31:0] new_word = {1'b0, lost, push_chain, push_src, push_erc, push_rsid};

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (store) mem[wr_ptr] <= new_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      lost       <= 1'b0;
      armed      <= 1'b1;
      pop_ack    <= 1'b0;
      pop_status <= 1'b0;
      pop_word   <= '0;
      mchk_pulse <= 1'b0;
    end else begin
      if (store)  wr_ptr <= step_ptr(wr_ptr);
      if (do_pop) rd_ptr <= step_ptr(rd_ptr);
      if (store && !do_pop)      count <= count + 1'b1;
      else if (!store && do_pop) count <= count - 1'b1;
      if (accept)          lost <= 1'b0;
      else if (push_valid) lost <= 1'b1;
      armed      <= (armed && !accept) || empty_rd;
      mchk_pulse <= accept && armed;
      pop_ack    <= pop_req;
      pop_status <= empty_rd;
      pop_word   <= do_pop ? mem[rd_ptr] : (bypass ? new_word : '0);
    end
  end
endmodule

// File: rtl/crw_queue_chk.sv
module crw_queue_chk #(
  parameter int DEPTH = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         push_valid,
  input logic                         pop_req,
  input logic                         pop_ack,
  input logic                         pop_status,
  input logic [31:0]                  pop_word,
  input logic                         mchk_pulse,
  input logic [$clog2(DEPTH+1)-1:0]   count
);
  AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req |=> pop_ack); // R2
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ack && pop_status) |-> (pop_word == 32'h0)); // R3
  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ack |-> !pop_word[31]); // R1
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH+1))'(DEPTH)); // R4
  AST_MCHK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mchk_pulse |=> !mchk_pulse); // R6
  AST_MCHK_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    mchk_pulse |-> $past(push_valid)); // R6
endmodule

bind crw_queue crw_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .pop_req(pop_req),
  .pop_ack(pop_ack), .pop_status(pop_status), .pop_word(pop_word),
  .mchk_pulse(mchk_pulse), .count(count)
);

// File: tb/sim_crw_queue.sv
module sim_crw_queue;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic [4:0]  push_src = '0;
  logic [7:0]  push_erc = '0;
  logic        push_chain = 1'b0;
  logic [15:0] push_rsid = '0;
  logic        pop_req = 1'b0;
  logic        pop_ack, pop_status, mchk_pulse;
  logic [31:0] pop_word;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  crw_queue #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_src(push_src),
    .push_erc(push_erc), .push_chain(push_chain), .push_rsid(push_rsid),
    .pop_req(pop_req), .pop_ack(pop_ack), .pop_status(pop_status),
    .pop_word(pop_word), .mchk_pulse(mchk_pulse)
  );

  logic [31:0] mq[$];
  bit          m_lost, m_arm;
  logic [34:0] exp_q[$];
  string       tag_q[$];

  task automatic model_reset();
    mq.delete();
    m_lost = 1'b0;
    m_arm  = 1'b1;
  endtask

  task automatic step(input bit pv, input logic [4:0] s, input logic [7:0] e,
                      input bit ch, input logic [15:0] id, input bit pr, input string tag);
    logic [31:0] w, resp;
    bit emp, ful, dpop, acc, st, mc;
    @(negedge clk);
    push_valid = pv; push_src = s; push_erc = e; push_chain = ch;
    push_rsid = id; pop_req = pr;
    w    = {1'b0, m_lost, ch, s, e, id};
    emp  = (mq.size() == 0);
    ful  = (mq.size() == DEPTH);
    dpop = pr && !emp;
    acc  = pv && (!ful || dpop);
    resp = 32'h0; st = 1'b0;
    if (pr) begin
      if (!emp) resp = mq[0];
      else if (acc) resp = w;
      else begin st = 1'b1; end
    end
    mc = acc && m_arm;
    if (acc) m_arm = 1'b0;
    if (pr && emp && !acc) m_arm = 1'b1;
    if (dpop) void'(mq.pop_front());
    if (acc && !(pr && emp)) mq.push_back(w);
    if (acc) m_lost = 1'b0; else if (pv) m_lost = 1'b1;
    exp_q.push_back({pr, mc, st, resp});
    tag_q.push_back(tag);
  endtask

  task automatic push(input logic [4:0] s, input logic [7:0] e, input bit ch,
                      input logic [15:0] id, input string tag);
    step(1'b1, s, e, ch, id, 1'b0, tag);
  endtask

  task automatic pop(input string tag);
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, tag);
  endtask

  task automatic idle();
    step(1'b0, '0, '0, 1'b0, '0, 1'b0, "idle");
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && exp_q.size() > 0) begin
      logic [34:0] ex;
      string t;
      ex = exp_q.pop_front();
      t  = tag_q.pop_front();
      check({t, " ack"},  {31'h0, pop_ack},    {31'h0, ex[34]});
      check({t, " mchk"}, {31'h0, mchk_pulse}, {31'h0, ex[33]});
      if (ex[34]) begin
        check({t, " status"}, {31'h0, pop_status}, {31'h0, ex[32]});
        check({t, " word"},   pop_word,            ex[31:0]);
      end
    end
  end

  task automatic do_reset();
    idle();
    @(posedge clk); #3;
    rst_n = 1'b0;
    model_reset();
    @(negedge clk); @(negedge clk);
    check("R8 reset ack",  {31'h0, pop_ack},    32'h0);
    check("R8 reset stat", {31'h0, pop_status}, 32'h0);
    check("R8 reset word", pop_word,            32'h0);
    check("R8 reset mchk", {31'h0, mchk_pulse}, 32'h0);
    rst_n = 1'b1;
  endtask

  initial begin
    model_reset();
    do_reset();
    push(5'h03, 8'h21, 1'b1, 16'hA001, "R1 R6 first push armed");
    push(5'h1F, 8'hFF, 1'b0, 16'h5555, "R6 second push no pulse");
    push(5'h00, 8'h01, 1'b1, 16'h0000, "R1 third push");
    pop("R1 R2 oldest");
    pop("R2 second");
    pop("R2 third");
    pop("R3 R7 empty pop");
    push(5'h0A, 8'h40, 1'b0, 16'h1234, "R7 rearmed push");
    pop("R2 single");
    for (int i = 0; i < DEPTH; i++) push(5'(i), 8'(i * 3), i[0], 16'(16'h100 + i), "R4 fill");
    push(5'h11, 8'h11, 1'b0, 16'hDEAD, "R4 lost when full");
    push(5'h12, 8'h12, 1'b1, 16'hBEEF, "R4 lost again");
    for (int i = 0; i < DEPTH; i++) pop("R2 R4 drain order");
    pop("R3 empty after drain");
    push(5'h05, 8'h06, 1'b0, 16'h7777, "R5 overflow marked push");
    push(5'h07, 8'h08, 1'b0, 16'h8888, "R5 marker cleared push");
    pop("R5 marker set");
    pop("R5 marker clear");
    pop("R7 empty rearm");
    step(1'b1, 5'h09, 8'h99, 1'b1, 16'h4242, 1'b1, "R9 bypass push+pop");
    pop("R9 queue stayed empty");
    for (int i = 0; i < DEPTH; i++) push(5'h14, 8'(i), 1'b0, 16'(16'h200 + i), "R10 fill");
    step(1'b1, 5'h15, 8'hAA, 1'b0, 16'h3333, 1'b1, "R10 full push+pop");
    push(5'h16, 8'hBB, 1'b0, 16'h4444, "R10 full again lost");
    for (int i = 0; i < DEPTH; i++) pop("R10 drain with new tail");
    push(5'h01, 8'h02, 1'b0, 16'h9999, "R5 after R10 loss");
    pop("R5 marker after R10");
    push(5'h02, 8'h03, 1'b0, 16'h1111, "R8 pre-reset push");
    push(5'h02, 8'h04, 1'b0, 16'h2222, "R8 pre-reset push");
    do_reset();
    pop("R8 empty after reset");
    push(5'h04, 8'h05, 1'b1, 16'h6666, "R8 armed after reset");
    pop("R8 post-reset entry");
    idle();
    @(posedge clk); #3;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule